// File: doc/BRIEF.md
# Switch-Driven Serial DAC Test Frame Generator

This block is a bus master that writes a 16-bit serial DAC again and again from a bank of eight static switches. On every frame it takes a snapshot of the switches and places them in a 24-bit write word. It then shifts the word out most significant bit first on a data line. A bit clock and an active-low frame strobe go with the data, in the usual framed format of DSP serial ports. After each frame the strobe stays high for a short idle gap, and then the next frame starts. No other input is needed, so a board can be checked with nothing more than the switches and a scope.

The bit clock is the system clock divided by the parameter `SCLK_DIV`, which must be even and at least 2. It has a 50% duty cycle, and each bit period starts with its high half. Data and strobe change only when the bit clock rises. The receiver therefore samples stable data on each falling edge. The two top switches select the power-down code. The other six supply the six most significant data bits, so the largest data code the block can send is 0xFC00.

Top module: `sw_frame_gen`

## Requirements
- R1: Each frame carries a 24-bit word, most significant bit first, one bit per bit-clock period. Frame bit 23 is present on `din_o` during the first period in which `sync_n_o` is low. `din_o` changes only in the system clock cycle in which `sclk_o` rises.
- R2: Frame bits 23 down to 18 are always sent as 0.
- R3: `sw_i[7]` is sent as frame bit 17 and `sw_i[6]` as frame bit 16; these two are the power-down code. `sw_i[5:0]` are sent as frame bits 15 down to 10, which are data bits 15 to 10.
- R4: Frame bits 9 down to 0 are always sent as 0. With all switches at 1 the word is 0x03FC00, so the data code is 0xFC00.
- R5: `sync_n_o` goes low at a rising edge of `sclk_o` and stays low for exactly 25 bit-clock periods. During that time there are exactly 25 falling edges of `sclk_o`.
- R6: Between frames, `sync_n_o` is high for exactly 3 bit-clock periods. A new frame therefore starts every 28 bit-clock periods, with no end.
- R7: `sclk_o` runs without stopping. It is high for `SCLK_DIV/2` system clocks and then low for `SCLK_DIV/2` system clocks.
- R8: The switches are sampled on the system clock edge at which a frame starts. A switch change at any later point has no effect on that frame.
- R9: While `rst_n` is low, `sync_n_o` is 1, `sclk_o` is 1 and `din_o` is 0. The first frame starts `SCLK_DIV` system clocks after the first clock edge at which `rst_n` is seen high.
- R10: `din_o` is 0 in every bit-clock period that does not carry one of the 24 frame bits: the 25th strobe-low period and the idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_i | input | 8 | Switch bank: [7:6] power-down code, [5:0] data MSBs |
| sclk_o | output | 1 | Bit clock, system clock divided by SCLK_DIV, idles high |
| sync_n_o | output | 1 | Frame strobe, active low |
| din_o | output | 1 | Serial data, MSB first |

## Verification
The bench toggles the switches pseudo-randomly every few cycles while frames are in flight. A design that samples the switches late, or shifts them straight from the pins, would send a mixed word; the bench would see it both in the per-cycle comparison and in the word it rebuilds at the falling edges. The bench also counts strobe-low falling edges and idle periods. An off-by-one in the period sequencer shows up as 24 or 26 edges, or as a wrong gap. A second instance with a divide ratio of 4 would catch a divider that only works at a ratio of 2. A mid-run reset checks that the idle levels hold during reset and that the frame start position after release is correct.

// File: rtl/sfg_pkg.sv
// Shared constants and the word packing function for the switch frame generator.
package sfg_pkg;
    localparam int FRAME_BITS        = 24;
    localparam int SW_BITS           = 8;
    localparam int SW_LSB            = 10;
    localparam int SYNC_LOW_PERIODS  = 25;
    localparam int SYNC_HIGH_PERIODS = 3;
    localparam int CYCLE_PERIODS     = SYNC_LOW_PERIODS + SYNC_HIGH_PERIODS;
    localparam int PER_W             = $clog2(CYCLE_PERIODS);

    typedef logic [FRAME_BITS-1:0] frame_word_t;

    // Places the switch bank at bits 17..10; every other bit is zero.
    function automatic frame_word_t pack_word(input logic [SW_BITS-1:0] sw);
        frame_word_t w;
        w = '0;
        w[SW_LSB +: SW_BITS] = sw;
        return w;
    endfunction
endpackage

// File: rtl/sfg_sclk_div.sv
// Bit clock divider.
// Produces a 50% duty bit clock from the system clock, high half first.
// It also flags the system cycle whose closing edge begins a new bit period,
// which is a rising edge of the bit clock.
// Assumes SCLK_DIV is even and >= 2. Reset is synchronous and active low.
module sfg_sclk_div #(
    parameter int SCLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk_o,
    output logic rise_next_o
);
    localparam int HALF   = SCLK_DIV / 2;
    localparam int HALF_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [HALF_W-1:0] half_cnt;
    logic              low_half;
    logic              half_end;

    assign half_end = (half_cnt == HALF_W'(HALF - 1));

    // Counts system clocks within a half period and flips the half at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            low_half <= 1'b0;
        end else if (half_end) begin
            half_cnt <= '0;
            low_half <= ~low_half;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    assign sclk_o      = ~low_half;
    assign rise_next_o = half_end & low_half;
endmodule

// File: rtl/sfg_frame_seq.sv
// Period sequencer.
// Steps a bit-period counter through a 28-period cycle: 25 strobe-low
// periods followed by 3 idle periods. It drives the frame strobe and requests
// a word load at the edge that begins period 0.
// Assumes rise_next_i comes from the bit clock divider. Reset parks the counter
// in the last idle period.
module sfg_frame_seq
    import sfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_next_i,
    output logic sync_n_o,
    output logic load_o
);
    localparam logic [PER_W-1:0] LAST_PER = PER_W'(CYCLE_PERIODS - 1);
    localparam logic [PER_W-1:0] GAP_PER  = PER_W'(SYNC_LOW_PERIODS);

    logic [PER_W-1:0] per_cnt;
    logic [PER_W-1:0] per_nxt;

    // Works out the period index that the next rising edge enters.
    always_comb begin
        per_nxt = (per_cnt == LAST_PER) ? '0 : per_cnt + 1'b1;
    end

    assign load_o = rise_next_i & (per_cnt == LAST_PER);

    // Moves to the next period and updates the strobe on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt  <= LAST_PER;
            sync_n_o <= 1'b1;
        end else if (rise_next_i) begin
            per_cnt  <= per_nxt;
            sync_n_o <= (per_nxt >= GAP_PER);
        end
    end

    // R6
    per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_cnt <= LAST_PER);

    // R5
    frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (!sync_n_o && per_cnt == '0));
endmodule

// File: rtl/sfg_word_shifter.sv
// Word shifter.
// Loads the packed switch word when a frame starts and shifts it left by one
// at every later rising edge of the bit clock. Zeros fill from the bottom, so
// once 24 bits have gone out the output stays low.
// Assumes load_i has priority when it coincides with shift_i.
module sfg_word_shifter
    import sfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic [SW_BITS-1:0] sw_i,
    output logic               msb_o
);
    frame_word_t shreg;

    // Snapshots the switches at frame start, otherwise shifts toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load_i) begin
            shreg <= pack_word(sw_i);
        end else if (shift_i) begin
            shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign msb_o = shreg[FRAME_BITS-1];

    // R2
    top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (shreg[FRAME_BITS-1:SW_LSB+SW_BITS] == '0));

    // R4
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (shreg[SW_LSB-1:0] == '0));
endmodule

// File: rtl/sw_frame_gen.sv
// Switch-driven serial test frame generator (top).
// Repeats 24-bit DAC write frames built from eight switches, using a framed
// serial format: the strobe is low for 25 bit periods and high for 3, and data
// changes on rising bit-clock edges, MSB first.
// Assumes the switches are static or already debounced. SCLK_DIV must be even
// and >= 2. Reset is synchronous and active low.
module sw_frame_gen #(
    parameter int SCLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sw_i,
    output logic       sclk_o,
    output logic       sync_n_o,
    output logic       din_o
);
    logic rise_next;
    logic load;

    // Bit clock and period-boundary strobe.
    sfg_sclk_div #(.SCLK_DIV(SCLK_DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_o     (sclk_o),
        .rise_next_o(rise_next)
    );

    // Frame strobe and load request.
    sfg_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_next_i(rise_next),
        .sync_n_o   (sync_n_o),
        .load_o     (load)
    );

    // Serial data path.
    sfg_word_shifter u_shf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .shift_i(rise_next),
        .sw_i   (sw_i),
        .msb_o  (din_o)
    );

    // R1
    din_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(din_o) |-> $rose(sclk_o));

    // R5
    sync_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_n_o) |-> $rose(sclk_o));

    // R10
    idle_din_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n_o |-> !din_o);
endmodule

// File: tb/sw_frame_gen_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every system clock for two
// divide ratios, plus a word rebuilt from DIN at falling bit-clock edges.
module sw_frame_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sw = 8'h00;
    logic       sclk2, sync2, din2, sclk4, sync4, din4;

    int checks = 0;
    int fails = 0;
    int n2 = 0;
    int n4 = 0;
    logic [23:0] word2 = '0;
    logic [23:0] word4 = '0;
    logic [23:0] cap = '0;
    int   cap_cnt = 0;
    logic prev_sclk = 1'b1;
    logic prev_sync = 1'b1;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    sw_frame_gen #(.SCLK_DIV(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_i(sw),
        .sclk_o(sclk2), .sync_n_o(sync2), .din_o(din2));

    sw_frame_gen #(.SCLK_DIV(4)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .sw_i(sw),
        .sclk_o(sclk4), .sync_n_o(sync4), .din_o(din4));

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    // Position after n released edges, with the period counter starting at 27.
    function automatic int per_of(input int n, input int div);
        return ((n + 27 * div) / div) % 28;
    endfunction

    function automatic int within_of(input int n, input int div);
        return (n + 27 * div) % div;
    endfunction

    function automatic logic [23:0] packw(input logic [7:0] s);
        // R3: sw[7]->bit17, sw[6]->bit16, sw[5:0]->bits 15..10; R2/R4 zeros
        return {6'b0, s, 10'b0};
    endfunction

    function automatic string din_tag(input int per);
        if (per >= 24) return "R10";
        if (per < 6)   return "R2";
        if (per < 14)  return "R3";
        return "R4";
    endfunction

    task automatic cmp_dut(input int n, input int div, input logic [23:0] w,
                           input logic a_sclk, input logic a_sync,
                           input logic a_din);
        int per, wi;
        logic e_sclk, e_sync, e_din;
        per = per_of(n, div);
        wi  = within_of(n, div);
        e_sclk = (wi < div / 2);
        e_sync = (per >= 25);
        e_din  = (per < 24) ? w[23 - per] : 1'b0;
        if (!rst_n) begin
            chk(a_sclk == 1'b1 && a_sync == 1'b1 && a_din == 1'b0, "R9",
                "reset idle levels", {a_sclk, a_sync, a_din}, 3'b110);
        end else begin
            chk(a_sclk == e_sclk, "R7", "sclk", a_sclk, e_sclk);
            chk(a_sync == e_sync, "R5/R6", "sync_n", a_sync, e_sync);
            chk(a_din == e_din, din_tag(per), "din", a_din, e_din);
        end
    endtask

    // One system cycle: advance the model past the edge, then compare.
    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            n2++;
            n4++;
        end else begin
            n2 = 0;
            n4 = 0;
        end
        // R8: the snapshot comes from the switch value held across the start edge
        if (rst_n && per_of(n2, 2) == 0 && within_of(n2, 2) == 0) word2 = packw(sw);
        if (rst_n && per_of(n4, 4) == 0 && within_of(n4, 4) == 0) word4 = packw(sw);
        cmp_dut(n2, 2, word2, sclk2, sync2, din2);
        cmp_dut(n4, 4, word4, sclk4, sync4, din4);
        // Rebuild the word from DIN at falling bit-clock edges while the strobe is low
        if (!rst_n) begin
            cap_cnt = 0;
            cap = '0;
        end else begin
            if (prev_sclk && !sclk2 && !sync2) begin
                if (cap_cnt < 24) cap = {cap[22:0], din2};
                cap_cnt++;
            end
            if (!prev_sync && sync2) begin
                // R1: the word read MSB first at falling edges matches the snapshot
                chk(cap == word2, "R1", "rebuilt frame word", cap, word2);
                // R5: exactly 25 falling edges while the strobe is low
                chk(cap_cnt == 25, "R5", "falling edges per frame", cap_cnt, 25);
                cap_cnt = 0;
                cap = '0;
            end
        end
        prev_sclk = rst_n ? sclk2 : 1'b1;
        prev_sync = rst_n ? sync2 : 1'b1;
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) step();
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9: idle levels while reset is held
        run(4);
        sw = 8'hFF;
        @(negedge clk);
        rst_n = 1'b1;
        // R4: all switches high gives word 0x03FC00, data code 0xFC00
        run(230);
        chk(word2 == 24'h03FC00, "R4", "full-switch word", word2, 24'h03FC00);
        sw = 8'hA5;
        run(230);
        sw = 8'h40;      // R3: power-down code bit 16 only
        run(230);
        sw = 8'h80;      // R3: power-down code bit 17 only
        run(230);
        sw = 8'h01;
        run(230);
        // R8: switches change every few cycles, in the middle of frames
        for (int k = 0; k < 120; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sw = lfsr[7:0];
            run(7);
        end
        // R9: reset in the middle of a run, then release again
        rst_n = 1'b0;
        run(5);
        rst_n = 1'b1;
        sw = 8'h3C;
        run(300);
        sw = 8'h00;
        run(120);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule